// File: doc/BRIEF.md
# Guess-Match Random Digit Game

This block is a small push-button game. A decimal digit counter steps through 0 to 9 once per clock while it is running and wraps back to 0. Each press of a button flips it between running and frozen. Because the press lands at a moment the player cannot time to the clock, the frozen digit is effectively random. A 4-bit switch value sets the player's guess. The guess and the frozen digit share a two-digit, time-multiplexed seven-segment display. A buzzer sounds when the frozen digit equals the guess.

The block runs on a single slow clock. Display scanning is paced by an enable tick, not by a derived clock. The button is assumed to be debounced already. Inside the block it passes through a synchronizer and an edge detector, so a press acts once however long the button is held.

Top module: `digit_guess_game`

## Requirements
- R1: While running, the digit advances by one at every clock edge, and 9 is followed by 0. While frozen, the digit holds its value.
- R2: The button goes through a two-flop synchronizer and a rising-edge detector. A button level first sampled high at clock edge k flips the run flag at edge k+2. A level held high for many cycles flips it only once, so the first press starts counting and the next press stops it.
- R3: Each scan tick updates the display. The first tick after reset enables the ones position (en_ones=1, en_tens=0) and shows the frozen digit. The next tick enables the tens position (en_tens=1, en_ones=0) and shows the target. The two then alternate. Between ticks the display outputs hold their values.
- R4: Segment lines are active-low, seg_n[6:0] = g,f,e,d,c,b,a. The codes are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000. Any value above 9 blanks the position (1111111).
- R5: buzz is 1 exactly when the counter is frozen and the frozen digit equals target_sw. It stays 0 in every cycle the counter is running.
- R6: A target_sw value above 9 never sets buzz, and it shows as a blank tens position.
- R7: Reset (rst_n=0, sampled at a clock edge) sets the digit to 0, the counter to frozen and the scan phase to ones. It also clears both enables and blanks the segment lines. buzz is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Game clock; the digit steps once per edge while running |
| rst_n | input | 1 | Synchronous reset, active low |
| btn | input | 1 | Debounced push button, high while pressed |
| target_sw | input | 4 | Guessed digit from switches |
| scan_tick | input | 1 | One-cycle enable that advances the display scan |
| seg_n | output | 7 | Active-low segments, bit 6 = g down to bit 0 = a |
| en_ones | output | 1 | Enable for the ones (result) position |
| en_tens | output | 1 | Enable for the tens (target) position |
| buzz | output | 1 | High when the frozen digit matches the target |

## Verification
The assertions assume that btn is free of bounce at the clock rate and that scan_tick is a single-cycle pulse. They also assume that target_sw changes only between observations, so that the match check compares settled values. The stimulus holds btn for at least one full cycle and releases it for several cycles before the next press. It raises scan_tick for exactly one cycle per display step, and it changes target_sw only while the counter is frozen or during windows that check the buzzer is quiet. The expected digit comes from counting clock edges between the two presses, so the edge-to-edge timing of the synchronizer is checked through the displayed result.

// File: rtl/dgg_pkg.sv
// Shared definitions for the guess-match digit game.
// Assumes digits fit in four bits and a seven-segment display with active-low lines.
package dgg_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef enum logic {
        SHOW_ONES = 1'b0,
        SHOW_TENS = 1'b1
    } scan_phase_e;

    // Active-low segment pattern, bit 6 = g ... bit 0 = a; values above 9 blank.
    function automatic logic [SEG_W-1:0] seg_code(input logic [DIGIT_W-1:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'd0:    s = 7'b1000000;
            4'd1:    s = 7'b1111001;
            4'd2:    s = 7'b0100100;
            4'd3:    s = 7'b0110000;
            4'd4:    s = 7'b0011001;
            4'd5:    s = 7'b0010010;
            4'd6:    s = 7'b0000010;
            4'd7:    s = 7'b1111000;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0010000;
            default: s = 7'b1111111;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dgg_press_detect.sv
// Button synchronizer and rising-edge detector.
// Assumes the button is debounced upstream; emits a one-cycle pulse per press.
module dgg_press_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic press_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the asynchronous button.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= btn;
                end
            end else begin : g_next
                // Later stages pass the sample down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign press_pulse = sync_q[LAST] & ~prev_q;

    // R2: a press yields a single-cycle pulse.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> !press_pulse);
endmodule

// File: rtl/dgg_decade_runner.sv
// Run flag and decade counter.
// Assumes toggle_pulse lasts one cycle; counts 0..DIGIT_MAX while running.
module dgg_decade_runner
    import dgg_pkg::*;
#(
    parameter int DIGIT_MAX = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               toggle_pulse,
    output logic               running,
    output logic [DIGIT_W-1:0] digit
);
    localparam logic [DIGIT_W-1:0] TOP  = DIGIT_W'(DIGIT_MAX);
    localparam logic [DIGIT_W-1:0] STEP = DIGIT_W'(1);

    // Each press flips between counting and frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)            running <= 1'b0;
        else if (toggle_pulse) running <= ~running;
    end

    // Step the digit with wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       digit <= '0;
        else if (running) digit <= (digit == TOP) ? '0 : digit + STEP;
    end

    // R2: the run flag changes on every press pulse.
    a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_pulse |=> (running != $past(running)));
    // R1: wrap from the top digit back to zero.
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && digit == TOP) |=> (digit == '0));
    // R1: frozen digit holds.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(digit));
    // R1: digit never leaves the decimal range.
    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        digit <= TOP);
endmodule

// File: rtl/dgg_scan_driver.sv
// Two-position multiplexed display driver.
// Assumes scan_tick is a one-cycle enable; ones position is shown first after reset.
module dgg_scan_driver
    import dgg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_tick,
    input  logic [DIGIT_W-1:0] result_digit,
    input  logic [DIGIT_W-1:0] target_digit,
    output logic [SEG_W-1:0]   seg_n,
    output logic               en_ones,
    output logic               en_tens
);
    scan_phase_e phase_q;

    // Load the next position's pattern and enable on each scan tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SHOW_ONES;
            seg_n   <= '1;
            en_ones <= 1'b0;
            en_tens <= 1'b0;
        end else if (scan_tick) begin
            if (phase_q == SHOW_ONES) begin
                seg_n   <= seg_code(result_digit);
                en_ones <= 1'b1;
                en_tens <= 1'b0;
                phase_q <= SHOW_TENS;
            end else begin
                seg_n   <= seg_code(target_digit);
                en_ones <= 1'b0;
                en_tens <= 1'b1;
                phase_q <= SHOW_ONES;
            end
        end
    end

    // R3: never two positions lit at once.
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_ones, en_tens}));
    // R3: outputs hold between ticks.
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> ($stable(seg_n) && $stable(en_ones) && $stable(en_tens)));
    // R3: ones is followed by tens.
    a_r3_to_tens: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && en_ones) |=> en_tens);
    // R3: tens is followed by ones.
    a_r3_to_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && en_tens) |=> en_ones);
endmodule

// File: rtl/digit_guess_game.sv
// Top of the guess-match digit game: press detector, decade runner,
// display scan driver and match buzzer.
// Assumes one clock domain, a debounced button and a one-cycle scan enable.
module digit_guess_game
    import dgg_pkg::*;
#(
    parameter int DIGIT_MAX   = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn,
    input  logic [DIGIT_W-1:0] target_sw,
    input  logic               scan_tick,
    output logic [SEG_W-1:0]   seg_n,
    output logic               en_ones,
    output logic               en_tens,
    output logic               buzz
);
    localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(DIGIT_MAX);

    logic               press_pulse;
    logic               running;
    logic [DIGIT_W-1:0] digit;
    logic               target_ok;

    dgg_press_detect #(.SYNC_STAGES(SYNC_STAGES)) u_press (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn         (btn),
        .press_pulse (press_pulse)
    );

    dgg_decade_runner #(.DIGIT_MAX(DIGIT_MAX)) u_runner (
        .clk          (clk),
        .rst_n        (rst_n),
        .toggle_pulse (press_pulse),
        .running      (running),
        .digit        (digit)
    );

    dgg_scan_driver u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_tick    (scan_tick),
        .result_digit (digit),
        .target_digit (target_sw),
        .seg_n        (seg_n),
        .en_ones      (en_ones),
        .en_tens      (en_tens)
    );

    // Match only a frozen digit against an in-range guess, quiet in reset.
    assign target_ok = (target_sw <= TOP);
    assign buzz      = rst_n & ~running & target_ok & (digit == target_sw);

    // R5: silent while counting.
    a_r5_silent_running: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !buzz);
    // R6: out-of-range guesses never match.
    a_r6_no_match_high: assert property (@(posedge clk) disable iff (!rst_n)
        (target_sw > TOP) |-> !buzz);

    // R7: buzzer held low during reset.
    always_comb begin
        a_r7_reset_quiet: assert (rst_n !== 1'b0 || buzz == 1'b0);
    end
endmodule

// File: tb/tb_digit_guess_game.sv
module tb_digit_guess_game;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // Cycles to wait between start and stop presses, and target (-1 = use frozen digit).
    localparam int VWAIT [NVEC] = '{0, 3, 9, 23, 1, 14, 6, 30};
    localparam int VTGT  [NVEC] = '{-1, 4, -1, 12, -1, 0, 15, -1};
    // Active-low patterns (g..a) for 0..9, per R4.
    localparam logic [6:0] SEGS [10] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19,
                                         7'h12, 7'h02, 7'h78, 7'h00, 7'h10};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn = 1'b0;
    logic [3:0] target_sw = 4'd0;
    logic       scan_tick = 1'b0;
    logic [6:0] seg_n;
    logic       en_ones, en_tens, buzz;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_digit = 0;
    int phase = 0;     // 0: next tick shows ones
    int mark_start, mark_stop;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    digit_guess_game dut (
        .clk(clk), .rst_n(rst_n), .btn(btn), .target_sw(target_sw),
        .scan_tick(scan_tick), .seg_n(seg_n), .en_ones(en_ones),
        .en_tens(en_tens), .buzz(buzz)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Press for hold cycles, release, let the run flag settle; returns the mark.
    task automatic press(input int hold, output int mark);
        @(negedge clk);
        btn = 1'b1;
        mark = cyc;
        repeat (hold) @(negedge clk);
        btn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic scan_step();
        @(negedge clk);
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        phase = 1 - phase;
    endtask

    function automatic logic [6:0] pat(input int v);
        return (v >= 0 && v <= 9) ? SEGS[v] : 7'h7F;
    endfunction

    task automatic check_ones(input string req);
        if (phase == 1) scan_step();
        scan_step();
        check({req, " ones seg"}, seg_n, pat(exp_digit));
        check({req, " ones enables"}, {en_ones, en_tens}, 2'b10);
    endtask

    task automatic check_tens(input string req, input int tgt);
        if (phase == 0) scan_step();
        scan_step();
        check({req, " tens seg"}, seg_n, pat(tgt));
        check({req, " tens enables"}, {en_ones, en_tens}, 2'b01);
    endtask

    task automatic play(input int waitc);
        press(1, mark_start);
        repeat (waitc) @(negedge clk);
        press(1, mark_stop);
        exp_digit = (exp_digit + (mark_stop - mark_start)) % 10;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        check("R7 buzz low in reset", buzz, 0);
        check("R7 seg blank in reset", seg_n, 7'h7F);
        check("R7 enables off in reset", {en_ones, en_tens}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 frozen zero matches target 0", buzz, 1);
        check_ones("R7 digit zero after reset");

        // R1 R2 R4 R5 R6: table of plays
        for (int i = 0; i < NVEC; i++) begin
            int tgt;
            play(VWAIT[i]);
            tgt = (VTGT[i] < 0) ? exp_digit : VTGT[i];
            target_sw = 4'(tgt);
            @(negedge clk);
            check("R5 buzz on frozen compare", buzz, (tgt == exp_digit) ? 1 : 0);
            check_ones("R1 R4 frozen digit");
            check_tens("R3 R6 target digit", tgt);
            repeat (3) @(negedge clk);
            check_ones("R1 frozen digit holds");
        end

        // R2: long hold toggles only once
        press(12, mark_start);
        repeat (5) @(negedge clk);
        press(1, mark_stop);
        exp_digit = (exp_digit + (mark_stop - mark_start)) % 10;
        check_ones("R2 held button toggles once");

        // R5: silent while running even with matching targets
        press(1, mark_start);
        for (int k = 0; k < 24; k++) begin
            target_sw = 4'(k % 10);
            @(negedge clk);
            check("R5 quiet while running", buzz, 0);
        end
        press(1, mark_stop);
        exp_digit = (exp_digit + (mark_stop - mark_start)) % 10;
        target_sw = 4'(exp_digit);
        @(negedge clk);
        check("R5 match after stop", buzz, 1);
        target_sw = 4'(exp_digit == 9 ? 8 : exp_digit + 1);
        @(negedge clk);
        check("R5 mismatch after stop", buzz, 0);

        // R7: reset in the middle of a run
        press(1, mark_start);
        repeat (7) @(negedge clk);
        target_sw = 4'd0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run reset buzz", buzz, 0);
        check("R7 mid-run reset enables", {en_ones, en_tens}, 2'b00);
        check("R7 mid-run reset seg", seg_n, 7'h7F);
        @(negedge clk);
        rst_n = 1'b1;
        phase = 0;
        exp_digit = 0;
        repeat (6) @(negedge clk);
        check("R7 run flag cleared", buzz, 1);
        check_ones("R7 digit cleared and frozen");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule